// File: doc/BRIEF.md
# Dual-Address I2C Register Target

This block is an I2C target that answers on two 7-bit addresses. Each address opens its own bank of sixteen 8-bit registers. The block samples the SCL and SDA lines through synchronizers. It drives both lines open-drain through active-high pull-low enables. A controller on the bus sends a sub-address byte to load the register pointer. It then either streams write bytes into the bank or issues a repeated START and streams bytes back out. The pointer advances after every data byte.

A side port gives test logic direct write and read access to both banks. A not-ready input models a back end that is busy. When it is raised in the address acknowledge slot, the block refuses the address. When it is raised before a data byte is committed or fetched, the block holds SCL low until it drops.

Top module: `dual_bank_i2c_target`

## Requirements
- R1: After reset both pull-low enables are inactive and every register of both banks reads 0 through the side port.
- R2: The byte 3Ah (address 0011101b, R/W=0) is acknowledged and selects bank 0. The byte 3Ch (address 0011110b, R/W=0) is acknowledged and selects bank 1. R/W=1 (3Bh/3Dh) selects the same banks for reading.
- R3: An address byte that matches neither address is not acknowledged. SDA stays released from then until the next START.
- R4: In a write, the low 4 bits of the first byte after the address load the pointer. Every following byte is acknowledged and stored MSB first at the pointer. The pointer then increments, wrapping from 15 to 0.
- R5: After a sub-address, a repeated START and the read address, the block returns bank bytes MSB first. It starts at the pointer, increments after each byte and wraps from 15 to 0.
- R6: When the controller does not acknowledge a read byte, the block releases SDA and drives nothing more until the next START.
- R7: A START (SDA falling while SCL is high) at any point, even mid-byte, restarts address reception. A STOP (SDA rising while SCL is high) returns the block to idle.
- R8: The SDA pull-low enable changes only while SCL is low.
- R9: With not-ready high in the address acknowledge slot, the address is not acknowledged.
- R10: With not-ready high when a write byte is about to be committed, SCL is held low until not-ready falls. The byte is then acknowledged and stored normally.
- R11: A side-port write (bank select 0 = first bank) stores into the addressed register. The side-port read data shows that register combinationally.
- R12: If a bus write commit and a side-port write hit the same register in the same cycle, the bus value is kept.
- R13: The two banks are independent: writes through one address never change the other bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Sampled SCL bus level |
| sda_i | input | 1 | Sampled SDA bus level |
| scl_oe | output | 1 | Pull SCL low (clock stretch) |
| sda_oe | output | 1 | Pull SDA low (acknowledge, read data 0) |
| not_ready | input | 1 | Back end busy: refuse address, stretch data |
| hp_we | input | 1 | Side-port write strobe |
| hp_bank | input | 1 | Side-port bank select |
| hp_addr | input | 4 | Side-port register index |
| hp_wdata | input | 8 | Side-port write data |
| hp_rdata | output | 8 | Side-port read data |

## Verification
The bus write commit and a side-port write can land on the same register in the same clock cycle. The bench provokes this during a clock stretch. It lowers not-ready in the same cycle as it strobes a side-port write to the register the stretched byte targets, so the commit and the host write meet on one edge. It judges the result by reading the register back through the side port and expecting the bus byte. Constrained-random transfers, with a reference model of both banks, cover pointer wrap and bank independence.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

   localparam int NBANK = 2;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_SUB,
      ST_WDATA,
      ST_RDATA
   } tgt_state_e;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_i,
   output logic line_o,
   output logic rise_o,
   output logic fall_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("i2c_line_sync: STAGES must be at least 2");
   end

   logic [STAGES:0] pipe;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= '1;
      else        pipe <= {pipe[STAGES-1:0], line_i};
   end

   assign line_o = pipe[STAGES-1];
   assign rise_o = pipe[STAGES-1] & ~pipe[STAGES];
   assign fall_o = ~pipe[STAGES-1] & pipe[STAGES];

endmodule

// File: rtl/i2c_reg_bank.sv
module i2c_reg_bank #(
   parameter int DEPTH = 16,
   parameter int DW    = 8,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bus_we,
   input  logic [AW-1:0] bus_addr,
   input  logic [DW-1:0] bus_wdata,
   output logic [DW-1:0] bus_rdata,
   input  logic          host_we,
   input  logic [AW-1:0] host_addr,
   input  logic [DW-1:0] host_wdata,
   output logic [DW-1:0] host_rdata
);

   if ((1 << AW) != DEPTH) begin : g_bad_depth
      $error("i2c_reg_bank: DEPTH must be a power of two");
   end

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else begin
         for (int i = 0; i < DEPTH; i++) begin
            if (bus_we && bus_addr == AW'(i))        mem[i] <= bus_wdata;
            else if (host_we && host_addr == AW'(i)) mem[i] <= host_wdata;
         end
      end
   end

   assign bus_rdata  = mem[bus_addr];
   assign host_rdata = mem[host_addr];

   // R12
   bus_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_we |=> mem[$past(bus_addr)] == $past(bus_wdata));

endmodule

// File: rtl/dual_bank_i2c_target.sv
module dual_bank_i2c_target
   import i2c_tgt_pkg::*;
#(
   parameter logic [6:0] ADDR_A      = 7'h1D,
   parameter logic [6:0] ADDR_B      = 7'h1E,
   parameter int         DEPTH       = 16,
   parameter int         DW          = 8,
   parameter int         SYNC_STAGES = 2,
   localparam int        AW          = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          scl_i,
   input  logic          sda_i,
   output logic          scl_oe,
   output logic          sda_oe,
   input  logic          not_ready,
   input  logic          hp_we,
   input  logic          hp_bank,
   input  logic [AW-1:0] hp_addr,
   input  logic [DW-1:0] hp_wdata,
   output logic [DW-1:0] hp_rdata
);

   if (DW != 8) begin : g_bad_dw
      $error("dual_bank_i2c_target: bytes on the bus are 8 bits");
   end
   if (ADDR_A == ADDR_B) begin : g_bad_addr
      $error("dual_bank_i2c_target: the two addresses must differ");
   end

   localparam logic [NBANK*7-1:0] BANK_IDS = {ADDR_B, ADDR_A};

   // line conditioning
   logic scl_s, scl_rise, scl_fall;
   logic sda_s, sda_rise, sda_fall;

   i2c_line_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
      .clk(clk), .rst_n(rst_n), .line_i(scl_i),
      .line_o(scl_s), .rise_o(scl_rise), .fall_o(scl_fall));

   i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
      .clk(clk), .rst_n(rst_n), .line_i(sda_i),
      .line_o(sda_s), .rise_o(sda_rise), .fall_o(sda_fall));

   logic start_det, stop_det;
   assign start_det = sda_fall & scl_s;
   assign stop_det  = sda_rise & scl_s;

   // engine state
   tgt_state_e    state;
   logic [3:0]    bitcnt;
   logic          in_ack;
   logic [7:0]    shreg;
   logic [7:0]    txreg;
   logic          sel_bank;
   logic          rd_dir;
   logic          mack;
   logic [AW-1:0] ptr;
   logic          hold;
   logic          scl_oe_q;
   logic          sda_oe_q;

   // address decode, one comparator per bank
   logic [NBANK-1:0] hit;
   for (genvar b = 0; b < NBANK; b++) begin : g_match
      assign hit[b] = (shreg[7:1] == BANK_IDS[b*7 +: 7]);
   end

   // register banks
   logic [NBANK-1:0] bus_we, host_we;
   logic [DW-1:0]    bus_rd  [NBANK];
   logic [DW-1:0]    host_rd [NBANK];
   logic             wr_commit;

   for (genvar b = 0; b < NBANK; b++) begin : g_bank
      assign bus_we[b]  = wr_commit && (sel_bank == 1'(b));
      assign host_we[b] = hp_we && (hp_bank == 1'(b));
      i2c_reg_bank #(.DEPTH(DEPTH), .DW(DW)) u_bank (
         .clk(clk), .rst_n(rst_n),
         .bus_we(bus_we[b]), .bus_addr(ptr), .bus_wdata(shreg),
         .bus_rdata(bus_rd[b]),
         .host_we(host_we[b]), .host_addr(hp_addr), .host_wdata(hp_wdata),
         .host_rdata(host_rd[b]));
   end

   logic [7:0] cur_rd;
   assign cur_rd   = bus_rd[sel_bank];
   assign hp_rdata = host_rd[hp_bank];

   // back-end dependency and the event that advances the engine while SCL is low
   logic byte_full, need_be, ev;
   assign byte_full = !in_ack && (bitcnt == 4'd8);
   assign need_be   = (state == ST_WDATA && byte_full) ||
                      (in_ack && ((state == ST_ADDR && rd_dir) ||
                                  (state == ST_RDATA && mack)));
   assign ev        = (scl_fall && !(need_be && not_ready)) || (hold && !not_ready);
   assign wr_commit = ev && state == ST_WDATA && byte_full;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold     <= 1'b0;
         scl_oe_q <= 1'b0;
      end else begin
         scl_oe_q <= hold;
         if (start_det || stop_det)                 hold <= 1'b0;
         else if (scl_fall && need_be && not_ready) hold <= 1'b1;
         else if (hold && !not_ready)               hold <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         bitcnt   <= '0;
         in_ack   <= 1'b0;
         shreg    <= '0;
         txreg    <= '0;
         sel_bank <= 1'b0;
         rd_dir   <= 1'b0;
         mack     <= 1'b0;
         ptr      <= '0;
         sda_oe_q <= 1'b0;
      end else if (start_det) begin
         state    <= ST_ADDR;
         bitcnt   <= '0;
         in_ack   <= 1'b0;
         sda_oe_q <= 1'b0;
      end else if (stop_det) begin
         state    <= ST_IDLE;
         bitcnt   <= '0;
         in_ack   <= 1'b0;
         sda_oe_q <= 1'b0;
      end else begin
         unique case (state)
            ST_IDLE: ;
            ST_ADDR, ST_SUB, ST_WDATA: begin
               if (scl_rise && !in_ack && bitcnt < 4'd8) begin
                  shreg  <= {shreg[6:0], sda_s};
                  bitcnt <= bitcnt + 4'd1;
               end
               if (ev && byte_full) begin
                  if (state == ST_ADDR) begin
                     if ((|hit) && !not_ready) begin
                        sda_oe_q <= 1'b1;
                        in_ack   <= 1'b1;
                        sel_bank <= hit[1];
                        rd_dir   <= shreg[0];
                     end else begin
                        state <= ST_IDLE;
                     end
                  end else begin
                     if (state == ST_SUB) ptr <= shreg[AW-1:0];
                     else                 ptr <= ptr + 1'b1;
                     sda_oe_q <= 1'b1;
                     in_ack   <= 1'b1;
                  end
               end else if (ev && in_ack) begin
                  in_ack <= 1'b0;
                  bitcnt <= '0;
                  if (state == ST_ADDR && rd_dir) begin
                     state    <= ST_RDATA;
                     txreg    <= {cur_rd[6:0], 1'b0};
                     sda_oe_q <= ~cur_rd[7];
                     bitcnt   <= 4'd1;
                     ptr      <= ptr + 1'b1;
                  end else begin
                     state    <= (state == ST_ADDR) ? ST_SUB : ST_WDATA;
                     sda_oe_q <= 1'b0;
                  end
               end
            end
            ST_RDATA: begin
               if (scl_rise && in_ack) mack <= ~sda_s;
               if (ev) begin
                  if (!in_ack && bitcnt < 4'd8) begin
                     sda_oe_q <= ~txreg[7];
                     txreg    <= {txreg[6:0], 1'b0};
                     bitcnt   <= bitcnt + 4'd1;
                  end else if (byte_full) begin
                     sda_oe_q <= 1'b0;
                     in_ack   <= 1'b1;
                  end else if (mack) begin
                     in_ack   <= 1'b0;
                     txreg    <= {cur_rd[6:0], 1'b0};
                     sda_oe_q <= ~cur_rd[7];
                     bitcnt   <= 4'd1;
                     ptr      <= ptr + 1'b1;
                  end else begin
                     state    <= ST_IDLE;
                     in_ack   <= 1'b0;
                     sda_oe_q <= 1'b0;
                  end
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign scl_oe = scl_oe_q;
   assign sda_oe = sda_oe_q;

   // R7
   start_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_det |=> (state == ST_ADDR && bitcnt == 4'd0 && !sda_oe_q));

   // R7
   stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> state == ST_IDLE);

   // R10
   stretch_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      scl_oe_q |-> $past(not_ready, 2));

   // R3
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      state == ST_IDLE |-> !sda_oe_q);

   // R8
   sda_change_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(sda_oe_q) && !$past(start_det) && !$past(stop_det)) |-> !$past(scl_s));

endmodule

// File: tb/dual_bank_i2c_target_tb.sv
module dual_bank_i2c_target_tb;

   localparam int Q = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       m_scl_low = 1'b0;
   logic       m_sda_low = 1'b0;
   logic       not_ready = 1'b0;
   logic       hp_we = 1'b0;
   logic       hp_bank = 1'b0;
   logic [3:0] hp_addr = '0;
   logic [7:0] hp_wdata = '0;
   logic [7:0] hp_rdata;
   logic       scl_oe, sda_oe;
   logic       scl_bus, sda_bus;

   assign scl_bus = !(m_scl_low || scl_oe);
   assign sda_bus = !(m_sda_low || sda_oe);

   always #5 clk = ~clk;

   dual_bank_i2c_target u_dut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_bus), .sda_i(sda_bus),
      .scl_oe(scl_oe), .sda_oe(sda_oe), .not_ready(not_ready),
      .hp_we(hp_we), .hp_bank(hp_bank), .hp_addr(hp_addr),
      .hp_wdata(hp_wdata), .hp_rdata(hp_rdata));

   int total = 0;
   int fails = 0;
   logic [7:0] model [2][16];

   // R8 monitor: SDA drive changes must happen with SCL low
   int   edge_viol = 0;
   logic prev_oe = 1'b0;
   logic quiet_mon = 1'b0;
   int   quiet_hits = 0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (sda_oe !== prev_oe && scl_bus) edge_viol++;
         if (quiet_mon && sda_oe) quiet_hits++;
      end
      prev_oe = sda_oe;
   end

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] addr_byte(input int b, input bit rd);
      return {(b == 0) ? 7'h1D : 7'h1E, rd};
   endfunction

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic scl_up();
      m_scl_low = 1'b0;
      @(negedge clk);
      while (!scl_bus) @(negedge clk);
   endtask

   task automatic i2c_start();
      m_sda_low = 1'b0; wait_cyc(Q);
      scl_up();          wait_cyc(Q);
      m_sda_low = 1'b1;  wait_cyc(Q);
      m_scl_low = 1'b1;  wait_cyc(Q);
   endtask

   task automatic i2c_stop();
      m_sda_low = 1'b1;  wait_cyc(Q);
      scl_up();          wait_cyc(Q);
      m_sda_low = 1'b0;  wait_cyc(Q);
   endtask

   task automatic send_bit(input bit v);
      m_sda_low = !v;    wait_cyc(Q);
      scl_up();          wait_cyc(Q);
      m_scl_low = 1'b1;  wait_cyc(Q);
   endtask

   task automatic recv_bit(output bit v);
      m_sda_low = 1'b0;  wait_cyc(Q);
      scl_up();          wait_cyc(Q/2);
      v = sda_bus;       wait_cyc(Q/2);
      m_scl_low = 1'b1;  wait_cyc(Q);
   endtask

   task automatic write_byte(input logic [7:0] d, output bit ack);
      bit v;
      for (int i = 7; i >= 0; i--) send_bit(d[i]);
      recv_bit(v);
      ack = !v;
   endtask

   task automatic read_byte(input bit give_ack, output logic [7:0] d);
      bit v;
      for (int i = 7; i >= 0; i--) begin
         recv_bit(v);
         d[i] = v;
      end
      send_bit(!give_ack);
   endtask

   task automatic host_write(input int b, input int a, input logic [7:0] d);
      hp_we = 1'b1; hp_bank = b[0]; hp_addr = a[3:0]; hp_wdata = d;
      @(negedge clk);
      hp_we = 1'b0;
      model[b][a] = d;
   endtask

   task automatic host_read(input int b, input int a, output logic [7:0] d);
      hp_bank = b[0]; hp_addr = a[3:0];
      #1 d = hp_rdata;
   endtask

   task automatic bus_write(input int b, input int sub, input int n, input logic [7:0] seed);
      bit ack;
      int p = sub;
      i2c_start();
      write_byte(addr_byte(b, 0), ack);
      check(ack, "R2 write address ack", ack, 1);
      write_byte(8'(sub), ack);
      check(ack, "R4 sub-address ack", ack, 1);
      for (int i = 0; i < n; i++) begin
         logic [7:0] d = seed + 8'(i * 37);
         write_byte(d, ack);
         check(ack, "R4 data byte ack", ack, 1);
         model[b][p] = d;
         p = (p + 1) % 16;
      end
      i2c_stop();
   endtask

   task automatic bus_read(input int b, input int sub, input int n);
      bit ack;
      logic [7:0] d;
      int p = sub;
      i2c_start();
      write_byte(addr_byte(b, 0), ack);
      check(ack, "R2 write address ack", ack, 1);
      write_byte(8'(sub), ack);
      check(ack, "R5 sub-address ack", ack, 1);
      i2c_start();
      write_byte(addr_byte(b, 1), ack);
      check(ack, "R2 read address ack", ack, 1);
      for (int i = 0; i < n; i++) begin
         read_byte(i < n - 1, d);
         check(d === model[b][p], "R5 read byte", d, model[b][p]);
         p = (p + 1) % 16;
      end
      wait_cyc(2 * Q);
      check(sda_oe === 1'b0, "R6 released after controller NACK", sda_oe, 0);
      i2c_stop();
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++; total++;
      $display("FAIL watchdog expired actual=%0h expected=%0h", 1, 0);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      logic [7:0] d;
      bit ack;
      void'($urandom(32'h5EED_1234));
      for (int b = 0; b < 2; b++) for (int a = 0; a < 16; a++) model[b][a] = 8'h00;

      wait_cyc(5);
      // R1 reset state
      check(scl_oe === 1'b0, "R1 scl released", scl_oe, 0);
      check(sda_oe === 1'b0, "R1 sda released", sda_oe, 0);
      rst_n = 1'b1;
      wait_cyc(3);
      for (int b = 0; b < 2; b++) for (int a = 0; a < 16; a += 5) begin
         host_read(b, a, d);
         check(d === 8'h00, "R1 bank clear", d, 0);
      end

      // R11 side-port preload and read-back
      for (int a = 0; a < 16; a++) begin
         host_write(0, a, 8'h10 + 8'(a));
         host_write(1, a, 8'hC0 + 8'(a));
      end
      host_read(0, 7, d); check(d === 8'h17, "R11 side read bank0", d, 8'h17);
      host_read(1, 7, d); check(d === 8'hC7, "R11 side read bank1", d, 8'hC7);

      // R4 burst write with pointer wrap, bank 0
      bus_write(0, 14, 3, 8'h5A);
      host_read(0, 14, d); check(d === model[0][14], "R4 wrap write at 14", d, model[0][14]);
      host_read(0, 0, d);  check(d === model[0][0], "R4 wrap write at 0", d, model[0][0]);
      // R13 other bank unchanged
      host_read(1, 14, d); check(d === 8'hCE, "R13 bank1 untouched", d, 8'hCE);

      // R5 read with repeated START and wrap, bank 1
      bus_read(1, 15, 3);
      bus_read(0, 14, 3);

      // R3 address matching neither bank
      i2c_start();
      quiet_mon = 1'b1;
      write_byte({7'h1F, 1'b0}, ack);
      check(!ack, "R3 unmatched address NACK", ack, 0);
      write_byte(8'h00, ack);
      check(!ack, "R3 silent until START", ack, 0);
      quiet_mon = 1'b0;
      i2c_stop();
      check(quiet_hits == 0, "R3 SDA never driven", quiet_hits, 0);

      // R9 not ready during address phase
      not_ready = 1'b1;
      i2c_start();
      write_byte(addr_byte(1, 0), ack);
      check(!ack, "R9 busy address NACK", ack, 0);
      i2c_stop();
      not_ready = 1'b0;

      // R10 + R12 stretch, then bus commit collides with side write
      i2c_start();
      write_byte(addr_byte(1, 0), ack);
      check(ack, "R10 address ack", ack, 1);
      write_byte(8'h05, ack);
      check(ack, "R10 sub ack", ack, 1);
      @(negedge clk); not_ready = 1'b1;
      fork
         begin
            write_byte(8'hA5, ack);
         end
         begin
            while (!scl_oe) @(negedge clk);
            wait_cyc(20);
            check(scl_bus === 1'b0, "R10 SCL held low", scl_bus, 0);
            not_ready = 1'b0;
            hp_we = 1'b1; hp_bank = 1'b1; hp_addr = 4'd5; hp_wdata = 8'h3C;
            @(negedge clk);
            hp_we = 1'b0;
         end
      join
      check(ack, "R10 ack after stretch", ack, 1);
      i2c_stop();
      model[1][5] = 8'hA5;
      host_read(1, 5, d);
      check(d === 8'hA5, "R12 bus write wins", d, 8'hA5);

      // R7 START in the middle of an address byte
      i2c_start();
      send_bit(1'b0); send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
      i2c_start();
      write_byte(addr_byte(0, 0), ack);
      check(ack, "R7 restart address ack", ack, 1);
      write_byte(8'h09, ack);
      write_byte(8'h77, ack);
      check(ack, "R7 data after restart", ack, 1);
      i2c_stop();
      model[0][9] = 8'h77;
      host_read(0, 9, d);
      check(d === 8'h77, "R7 write after restart", d, 8'h77);

      // constrained random transfers against the model (R4 R5 R13)
      for (int t = 0; t < 14; t++) begin
         int b   = int'($urandom_range(1, 0));
         int sub = int'($urandom_range(15, 0));
         int n   = int'($urandom_range(4, 1));
         if ($urandom_range(1, 0) == 1) bus_write(b, sub, n, 8'($urandom));
         else                           bus_read(b, sub, n);
      end
      for (int b = 0; b < 2; b++) for (int a = 0; a < 16; a++) begin
         host_read(b, a, d);
         check(d === model[b][a], "R13 final bank contents", d, model[b][a]);
      end

      check(edge_viol == 0, "R8 SDA drive changed with SCL high", edge_viol, 0);

      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

endmodule